// File: doc/BRIEF.md
# Read Tag and Completion Credit Manager

This block sits between several read requesters and the outbound path of a PCIe-style link. Before a requester builds a read request, it asks for a transaction tag and states how many completion header and data credits the replies will need. A tag is granted only when a tag is unused and both completion credit pools can absorb the replies. Tags that are granted but not yet sent are counted as reserved. Because of this, replies that arrive later can never overflow the receive buffer.

Each tag keeps an allocation flag, a sent flag, the requester that owns it, the time the request went out and the header and data credit it still owes. Credit leaves the pools when the request is sent and returns as completions arrive. A scan pointer visits one tag per cycle and retires any sent tag that has been outstanding for too long. When it does, it returns the tag's remaining credit, tells the owning requester and raises a completion-error pulse. The grant is decided in the same cycle as the request and never stalls. A requester that is refused can withdraw, so other outbound traffic can go ahead.

Top module: `rd_tag_credit_mgr`

## Requirements
- R1: After reset the header pool holds HDR_POOL (8) and the data pool holds DAT_POOL (64). No tag is held and no grant, timeout, error or unexpected pulse is asserted.
- R2: A requester whose need fits is granted in the same cycle as its request, with `gnt` and `gnt_tag` driven combinationally. A requester fits only when a tag is free and its header need is no more than the header pool minus reserved header credit. Its data need must likewise fit the data pool minus reserved data credit. If either check fails, no grant is given.
- R3: At most one grant is given per cycle. It goes to the lowest-index requester whose need fits, so a requester that does not fit never blocks one that does. The granted tag is the lowest-index free tag. `gnt` is one-hot with bit i meaning requester i.
- R4: Granting a tag leaves the pools unchanged. Credit is debited from the pools when `snd_valid` names a granted tag that has not yet been sent.
- R5: A completion that is not the last for a sent tag returns the received amount to each pool, capped at what the tag still owes. The tag's owed credit drops by the same amount.
- R6: A completion with `cpl_last` set for a sent tag returns all of that tag's remaining owed credit and frees the tag for reuse.
- R7: A sent tag that has been outstanding for `to_limit` or more cycles (free-running counter minus stored send time) is retired by the scan, which visits one tag per cycle. Retiring the tag returns its owed credit to the pools and frees it.
- R8: When a tag times out, `to_valid` pulses for one cycle with the owner's index on `to_req` and the tag on `to_tag`, and `cpl_err` pulses in the same cycle.
- R9: A completion for a tag that is not sent (free, or granted but unsent) pulses `cpl_unexp` and leaves the pools unchanged.
- R10: Neither pool ever exceeds its initial size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Per-requester tag request |
| req_hdr | input | NUM_REQ*HW | Header credit need, HW bits per requester |
| req_dat | input | NUM_REQ*DW | Data credit need, DW bits per requester |
| gnt | output | NUM_REQ | One-hot grant |
| gnt_tag | output | TW | Tag handed out with the grant |
| snd_valid | input | 1 | Read request for `snd_tag` is sent now |
| snd_tag | input | TW | Tag of the sent request |
| to_limit | input | TS_W | Timeout threshold in cycles |
| cpl_valid | input | 1 | Completion arrived |
| cpl_tag | input | TW | Completion tag |
| cpl_hdr | input | HW | Header credit consumed by the completion |
| cpl_dat | input | DW | Data credit consumed by the completion |
| cpl_last | input | 1 | Final completion for the tag |
| to_valid | output | 1 | Timeout notice to requester |
| to_req | output | RW | Owner of the timed-out tag |
| to_tag | output | TW | Timed-out tag |
| cpl_err | output | 1 | Completion-error pulse on timeout |
| cpl_unexp | output | 1 | Completion for a tag that was not sent |
| hdr_pool | output | HW | Header credit currently in the pool |
| dat_pool | output | DW | Data credit currently in the pool |

## Verification
Several stimulus patterns exercise grant selection. Two requesters asking together show fixed priority. A request that fails only the header check and one that fails only the data check show that each pool is tested separately. A large request paired with a small one shows that a refused requester does not block another. A request made with every tag held shows refusal for lack of tags. Completions are sent as a partial followed by a short final one, which separates the capped per-piece return from the return of the whole remainder. Completions aimed at a timed-out tag and at a granted but unsent tag both have to be flagged without moving the pools. Lowering the limit at the end sets off a timeout that must name the right owner and tag.

// File: rtl/rd_tag_credit_mgr.sv
module rd_tag_credit_mgr #(
  parameter int NUM_REQ  = 3,
  parameter int NUM_TAGS = 4,
  parameter int HW       = 6,
  parameter int DW       = 8,
  parameter int HDR_POOL = 8,
  parameter int DAT_POOL = 64,
  parameter int TS_W     = 12,
  localparam int TW = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REQ-1:0]    req_valid,
  input  logic [NUM_REQ*HW-1:0] req_hdr,
  input  logic [NUM_REQ*DW-1:0] req_dat,
  output logic [NUM_REQ-1:0]    gnt,
  output logic [TW-1:0]         gnt_tag,
  input  logic                  snd_valid,
  input  logic [TW-1:0]         snd_tag,
  input  logic [TS_W-1:0]       to_limit,
  input  logic                  cpl_valid,
  input  logic [TW-1:0]         cpl_tag,
  input  logic [HW-1:0]         cpl_hdr,
  input  logic [DW-1:0]         cpl_dat,
  input  logic                  cpl_last,
  output logic                  to_valid,
  output logic [RW-1:0]         to_req,
  output logic [TW-1:0]         to_tag,
  output logic                  cpl_err,
  output logic                  cpl_unexp,
  output logic [HW-1:0]         hdr_pool,
  output logic [DW-1:0]         dat_pool
);
  localparam logic [HW-1:0] HINIT = HW'(HDR_POOL);
  localparam logic [DW-1:0] DINIT = DW'(DAT_POOL);

  logic [NUM_TAGS-1:0] alloc, sent;
  logic [RW-1:0]   owner [NUM_TAGS];
  logic [TS_W-1:0] ts    [NUM_TAGS];
  logic [HW-1:0]   owe_h [NUM_TAGS];
  logic [DW-1:0]   owe_d [NUM_TAGS];
  logic [HW-1:0]   res_h;
  logic [DW-1:0]   res_d;
  logic [TS_W-1:0] now;
  logic [TW-1:0]   scan;

  logic          free_ok, pick_ok;
  logic [TW-1:0] free_tag;
  logic [RW-1:0] pick;
  logic [HW-1:0] avail_h, pick_h;
  logic [DW-1:0] avail_d, pick_d;

  assign avail_h = hdr_pool - res_h;
  assign avail_d = dat_pool - res_d;

  always_comb begin
    free_ok  = 1'b0;
    free_tag = '0;
    for (int t = NUM_TAGS-1; t >= 0; t--)
      if (!alloc[t]) begin
        free_ok  = 1'b1;
        free_tag = TW'(t);
      end
  end

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    pick_h  = '0;
    pick_d  = '0;
    for (int i = NUM_REQ-1; i >= 0; i--)
      if (req_valid[i] && req_hdr[i*HW +: HW] <= avail_h && req_dat[i*DW +: DW] <= avail_d) begin
        pick_ok = 1'b1;
        pick    = RW'(i);
        pick_h  = req_hdr[i*HW +: HW];
        pick_d  = req_dat[i*DW +: DW];
      end
  end

  logic grant;
  assign grant   = free_ok && pick_ok;
  assign gnt     = grant ? (NUM_REQ'(1) << pick) : '0;
  assign gnt_tag = free_tag;

  logic snd_ok, cpl_ok, to_hit;
  logic [HW-1:0] snd_h, cr_h, to_h;
  logic [DW-1:0] snd_d, cr_d, to_d;

  assign snd_ok = snd_valid && alloc[snd_tag] && !sent[snd_tag];
  assign snd_h  = snd_ok ? owe_h[snd_tag] : '0;
  assign snd_d  = snd_ok ? owe_d[snd_tag] : '0;

  assign cpl_ok = cpl_valid && sent[cpl_tag];
  assign cr_h   = !cpl_ok ? '0 : (cpl_last || cpl_hdr > owe_h[cpl_tag]) ? owe_h[cpl_tag] : cpl_hdr;
  assign cr_d   = !cpl_ok ? '0 : (cpl_last || cpl_dat > owe_d[cpl_tag]) ? owe_d[cpl_tag] : cpl_dat;

  assign to_hit = sent[scan] && (now - ts[scan] >= to_limit) && !(cpl_ok && cpl_tag == scan);
  assign to_h   = to_hit ? owe_h[scan] : '0;
  assign to_d   = to_hit ? owe_d[scan] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc     <= '0;
      sent      <= '0;
      hdr_pool  <= HINIT;
      dat_pool  <= DINIT;
      res_h     <= '0;
      res_d     <= '0;
      now       <= '0;
      scan      <= '0;
      to_valid  <= 1'b0;
      to_req    <= '0;
      to_tag    <= '0;
      cpl_err   <= 1'b0;
      cpl_unexp <= 1'b0;
      for (int t = 0; t < NUM_TAGS; t++) begin
        owner[t] <= '0;
        ts[t]    <= '0;
        owe_h[t] <= '0;
        owe_d[t] <= '0;
      end
    end else begin
      now       <= now + 1'b1;
      scan      <= (scan == TW'(NUM_TAGS-1)) ? '0 : scan + 1'b1;
      hdr_pool  <= hdr_pool - snd_h + cr_h + to_h;
      dat_pool  <= dat_pool - snd_d + cr_d + to_d;
      res_h     <= res_h - snd_h + (grant ? pick_h : '0);
      res_d     <= res_d - snd_d + (grant ? pick_d : '0);
      to_valid  <= to_hit;
      cpl_err   <= to_hit;
      to_req    <= owner[scan];
      to_tag    <= scan;
      cpl_unexp <= cpl_valid && !sent[cpl_tag];

      if (grant) begin
        alloc[free_tag] <= 1'b1;
        owner[free_tag] <= pick;
        owe_h[free_tag] <= pick_h;
        owe_d[free_tag] <= pick_d;
      end
      if (snd_ok) begin
        sent[snd_tag] <= 1'b1;
        ts[snd_tag]   <= now;
      end
      if (cpl_ok) begin
        owe_h[cpl_tag] <= owe_h[cpl_tag] - cr_h;
        owe_d[cpl_tag] <= owe_d[cpl_tag] - cr_d;
        if (cpl_last) begin
          alloc[cpl_tag] <= 1'b0;
          sent[cpl_tag]  <= 1'b0;
        end
      end
      if (to_hit) begin
        alloc[scan] <= 1'b0;
        sent[scan]  <= 1'b0;
        owe_h[scan] <= '0;
        owe_d[scan] <= '0;
      end
    end
  end

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r3_grant_free_tag: assert property (@(posedge clk) disable iff (!rst_n)
    |gnt |-> !alloc[gnt_tag]);
  a_r2_grant_holds_tag: assert property (@(posedge clk) disable iff (!rst_n)
    |gnt |=> alloc[$past(gnt_tag)]);
  a_r6_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_last && sent[cpl_tag]) |=> !alloc[$past(cpl_tag)]);
  a_r7_timeout_freed: assert property (@(posedge clk) disable iff (!rst_n)
    to_valid |-> !sent[to_tag]);
  a_r10_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pool <= HINIT && dat_pool <= DINIT);
endmodule

// File: tb/tb_rd_tag_credit_mgr.sv
module tb_rd_tag_credit_mgr;
  localparam int NR = 3, NT = 4, HW = 6, DW = 8, TSW = 12;
  localparam int TW = 2, RW = 2;

  logic clk = 0, rst_n = 0;
  logic [NR-1:0] req_valid = '0;
  logic [NR*HW-1:0] req_hdr = '0;
  logic [NR*DW-1:0] req_dat = '0;
  logic [NR-1:0] gnt;
  logic [TW-1:0] gnt_tag;
  logic snd_valid = 0;
  logic [TW-1:0] snd_tag = '0;
  logic [TSW-1:0] to_limit = 12'd4000;
  logic cpl_valid = 0, cpl_last = 0;
  logic [TW-1:0] cpl_tag = '0;
  logic [HW-1:0] cpl_hdr = '0;
  logic [DW-1:0] cpl_dat = '0;
  logic to_valid, cpl_err, cpl_unexp;
  logic [RW-1:0] to_req;
  logic [TW-1:0] to_tag;
  logic [HW-1:0] hdr_pool;
  logic [DW-1:0] dat_pool;

  int errors = 0, checks = 0;
  int exp_q[$];

  rd_tag_credit_mgr dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // item encoding: kind*100 + a*10 + b ; kind 1 grant(req,tag), 2 timeout(req,tag), 3 unexpected
  task automatic pop_cmp(input int got, input string req);
    if (exp_q.size() == 0) chk(0, req, got, -1);
    else begin
      int e = exp_q.pop_front();
      chk(got == e, req, got, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (|gnt) begin
      int idx = 0;
      for (int i = 0; i < NR; i++) if (gnt[i]) idx = i;
      pop_cmp(100 + idx*10 + int'(gnt_tag), "R3 grant");
    end
    if (to_valid) begin
      pop_cmp(200 + int'(to_req)*10 + int'(to_tag), "R8 timeout");
      chk(cpl_err, "R8 cpl_err", int'(cpl_err), 1);
    end
    if (cpl_unexp) pop_cmp(300, "R9 unexpected");
  end

  task automatic ask(input logic [NR-1:0] v, input int h0, d0, h1, d1, h2, d2);
    @(posedge clk); #1;
    req_valid = v;
    req_hdr = {HW'(h2), HW'(h1), HW'(h0)};
    req_dat = {DW'(d2), DW'(d1), DW'(d0)};
    @(posedge clk); #1;
    req_valid = '0;
  endtask

  task automatic ask_none(input logic [NR-1:0] v, input int h0, d0, h1, d1, h2, d2, input string req);
    @(posedge clk); #1;
    req_valid = v;
    req_hdr = {HW'(h2), HW'(h1), HW'(h0)};
    req_dat = {DW'(d2), DW'(d1), DW'(d0)};
    @(negedge clk);
    chk(gnt == 0, req, int'(gnt), 0);
    @(posedge clk); #1;
    req_valid = '0;
  endtask

  task automatic send(input int t);
    @(posedge clk); #1;
    snd_valid = 1; snd_tag = TW'(t);
    @(posedge clk); #1;
    snd_valid = 0;
  endtask

  task automatic cpl(input int t, input int h, input int d, input bit last);
    @(posedge clk); #1;
    cpl_valid = 1; cpl_tag = TW'(t); cpl_hdr = HW'(h); cpl_dat = DW'(d); cpl_last = last;
    @(posedge clk); #1;
    cpl_valid = 0; cpl_last = 0;
  endtask

  task automatic pools(input int h, input int d, input string req);
    @(negedge clk);
    chk(int'(hdr_pool) == h, {req, " hdr"}, int'(hdr_pool), h);
    chk(int'(dat_pool) == d, {req, " dat"}, int'(dat_pool), d);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(hdr_pool == 8 && dat_pool == 64, "R1 pools", int'(hdr_pool), 8);
    chk(gnt == 0 && !to_valid && !cpl_err && !cpl_unexp, "R1 quiet", int'(gnt), 0);

    exp_q.push_back(100);                       // R2 req0 -> tag0
    ask(3'b001, 2, 16, 0, 0, 0, 0);
    pools(8, 64, "R4 no debit at grant");
    exp_q.push_back(111);                       // R3 req1 beats req2
    ask(3'b110, 0, 0, 1, 8, 1, 8);
    exp_q.push_back(122);
    ask(3'b100, 0, 0, 0, 0, 1, 8);
    send(0);
    pools(6, 48, "R4 debit at send");
    ask_none(3'b001, 5, 4, 0, 0, 0, 0, "R2 header short");
    ask_none(3'b001, 1, 40, 0, 0, 0, 0, "R2 data short");
    exp_q.push_back(113);                       // R3 unfit req0 does not block req1
    ask(3'b011, 5, 4, 1, 4, 0, 0);
    ask_none(3'b100, 0, 0, 0, 0, 1, 1, "R2 no free tag");
    send(1); send(2); send(3);
    pools(3, 28, "R4 sends");
    cpl(0, 1, 8, 0);
    pools(4, 36, "R5 partial");
    cpl(0, 1, 4, 1);
    pools(5, 44, "R6 last returns rest");
    exp_q.push_back(120);                       // R6 tag0 reusable
    ask(3'b100, 0, 0, 0, 0, 1, 1);
    cpl(2, 1, 8, 1);
    cpl(3, 1, 4, 1);
    pools(7, 56, "R6 tags 2,3");
    exp_q.push_back(211);                       // R7 tag1 of req1 times out
    @(posedge clk); #1 to_limit = 12'd20;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    chk(exp_q.size() == 0, "R7 timeout seen", exp_q.size(), 0);
    pools(8, 64, "R7 credit back");
    exp_q.push_back(300);
    cpl(1, 1, 8, 1);
    pools(8, 64, "R9 after timeout");
    exp_q.push_back(300);
    cpl(0, 1, 1, 1);
    pools(8, 64, "R9 unsent tag");
    send(0);
    pools(7, 63, "R10 final send");
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule